// File: doc/BRIEF.md
# Software Interrupt Pending Register

This block holds a small set of pending software-interrupt flags for a processor core's privileged register space. Software reaches it in three ways, each selected by a write opcode. A plain load replaces the whole register. A set-alias write ORs new flags in. A clear-alias write drops every flag that is 1 in the written word. A read port always shows the stored flags, zero-extended to the full data width. A hardware strobe from the system timer raises the timer-match flag directly.

Each flag drives one interrupt request line. The request lines are the stored flags masked by the current processor interrupt level (a 4-bit input). The two timer-match flags, at bit 0 and bit 16, are masked as a pair whenever the level is 14 or above. Flag i, for i from 1 to 15, is passed only while i is strictly greater than the level. The mask is purely combinational, so a change of level shows on the request lines in the same cycle. Choosing among the requests and delivering the trap are done downstream.

Top module: `sip_softint_reg`

## Requirements
- R1: While reset is asserted, and after it is released, the register holds zero, read data is zero and no request line is active.
- R2: A write with opcode 0 (load) stores bits 16..0 of the write data. Bits 63..17 of the write data are ignored. Read data shows the stored value with bits 63..17 at zero, from the cycle after the write.
- R3: A write with opcode 1 (set) makes the new value the old value OR'd with bits 16..0 of the write data.
- R4: A write with opcode 2 (clear) makes the new value the old value AND the inverse of bits 16..0 of the write data.
- R5: Request bit 0 and request bit 16 follow their stored flags while the level is below 14. They are 0 while the level is 14 or 15.
- R6: For i from 1 to 15, request bit i is 1 exactly when flag i is set and i is strictly greater than the level.
- R7: The request lines respond to a change of level in the same cycle, with no write needed.
- R8: A cycle with the hardware timer strobe high leaves bit 16 set at the next edge. This holds even when the same cycle carries a clear or load write that would zero bit 16.
- R9: Opcode 3, or a cycle with the write enable low, leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_op | input | 2 | Write opcode: 0 load, 1 set, 2 clear, 3 none |
| wr_data | input | 64 | Write data |
| pil | input | 4 | Current processor interrupt level |
| hw_timer_set | input | 1 | Hardware strobe that raises bit 16 |
| rd_data | output | 64 | Stored flags, zero-extended |
| irq_req | output | 17 | Per-flag requests after the level mask |

## Verification
The bench builds the block with its default parameters: 17 flags, a 64-bit data path, a 4-bit level and a mask threshold of 14. With these values every level from 0 to 15 can be reached. That covers the edge between levels 13 and 14 for the timer pair, and the case where flag 15 is cut off only at level 15. The same widths also make the upper 47 write bits available for testing that they are dropped. They also allow a hardware strobe to coincide with a clear of bit 16.

// File: rtl/sip_pkg.sv
package sip_pkg;

   typedef enum logic [1:0] {
      SIP_OP_LOAD = 2'd0,
      SIP_OP_SET  = 2'd1,
      SIP_OP_CLR  = 2'd2,
      SIP_OP_NONE = 2'd3
   } sip_op_e;

endpackage

// File: rtl/sip_next.sv
module sip_next
   import sip_pkg::*;
#(
   parameter int NUM_BITS  = 17,
   parameter int TIMER_BIT = 16
) (
   input  logic                wr_en,
   input  sip_op_e             wr_op,
   input  logic [NUM_BITS-1:0] wr_bits,
   input  logic                hw_set,
   input  logic [NUM_BITS-1:0] cur,
   output logic [NUM_BITS-1:0] nxt,
   output logic                upd
);

   logic [NUM_BITS-1:0] sw_val;
   logic                sw_upd;

   // Software opcode selection (R2, R3, R4, R9)
   always_comb begin
      sw_val = cur;
      sw_upd = 1'b0;
      if (wr_en) begin
         unique case (wr_op)
            SIP_OP_LOAD: begin sw_val = wr_bits;        sw_upd = 1'b1; end
            SIP_OP_SET:  begin sw_val = cur | wr_bits;  sw_upd = 1'b1; end
            SIP_OP_CLR:  begin sw_val = cur & ~wr_bits; sw_upd = 1'b1; end
            default:     begin sw_val = cur;            sw_upd = 1'b0; end
         endcase
      end
   end

   // Hardware strobe applied after the software result: it wins (R8)
   always_comb begin
      nxt = sw_val;
      if (hw_set) nxt[TIMER_BIT] = 1'b1;
      upd = sw_upd | hw_set;
   end

endmodule

// File: rtl/sip_store.sv
module sip_store #(
   parameter int NUM_BITS = 17
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                upd,
   input  logic [NUM_BITS-1:0] nxt,
   output logic [NUM_BITS-1:0] q
);

   for (genvar b = 0; b < NUM_BITS; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   q[b] <= 1'b0;
         else if (upd) q[b] <= nxt[b];
      end
   end

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(q)); // R9

endmodule

// File: rtl/sip_level_mask.sv
module sip_level_mask #(
   parameter int NUM_BITS  = 17,
   parameter int PIL_W     = 4,
   parameter int TICK_BIT  = 0,
   parameter int TIMER_BIT = 16,
   parameter int THRESH    = 14
) (
   input  logic [NUM_BITS-1:0] pend,
   input  logic [PIL_W-1:0]    pil,
   output logic [NUM_BITS-1:0] req
);

   localparam int LVL_W = PIL_W + 1;

   logic [LVL_W-1:0] lvl;
   logic             below_thr;

   assign lvl       = {1'b0, pil};
   assign below_thr = (int'(lvl) < THRESH);

   for (genvar i = 0; i < NUM_BITS; i++) begin : g_req
      if (i == TICK_BIT || i == TIMER_BIT) begin : g_timer
         assign req[i] = pend[i] & below_thr;  // R5
      end else if (i >= (1 << PIL_W)) begin : g_always
         assign req[i] = pend[i];
      end else begin : g_level
         assign req[i] = pend[i] & (int'(lvl) < i);  // R6
      end
   end

endmodule

// File: rtl/sip_softint_reg.sv
module sip_softint_reg
   import sip_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter int NUM_BITS  = 17,
   parameter int PIL_W     = 4,
   parameter int TICK_BIT  = 0,
   parameter int TIMER_BIT = 16,
   parameter int THRESH    = 14
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [1:0]          wr_op,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [PIL_W-1:0]    pil,
   input  logic                hw_timer_set,
   output logic [DATA_W-1:0]   rd_data,
   output logic [NUM_BITS-1:0] irq_req
);

   localparam int PAD_W = DATA_W - NUM_BITS;

   if (NUM_BITS > DATA_W)         begin : g_chk_w   $error("NUM_BITS exceeds DATA_W");      end
   if (TIMER_BIT >= NUM_BITS)     begin : g_chk_tm  $error("TIMER_BIT out of range");       end
   if (TICK_BIT >= NUM_BITS)      begin : g_chk_tk  $error("TICK_BIT out of range");        end
   if (THRESH > (1 << PIL_W))     begin : g_chk_th  $error("THRESH beyond level range");    end

   sip_op_e             op;
   logic [NUM_BITS-1:0] wr_bits;
   logic [NUM_BITS-1:0] pend;
   logic [NUM_BITS-1:0] nxt;
   logic                upd;

   assign op      = sip_op_e'(wr_op);
   assign wr_bits = wr_data[NUM_BITS-1:0];

   sip_next #(.NUM_BITS(NUM_BITS), .TIMER_BIT(TIMER_BIT)) i_next (
      .wr_en  (wr_en),
      .wr_op  (op),
      .wr_bits(wr_bits),
      .hw_set (hw_timer_set),
      .cur    (pend),
      .nxt    (nxt),
      .upd    (upd)
   );

   sip_store #(.NUM_BITS(NUM_BITS)) i_store (
      .clk  (clk),
      .rst_n(rst_n),
      .upd  (upd),
      .nxt  (nxt),
      .q    (pend)
   );

   sip_level_mask #(
      .NUM_BITS (NUM_BITS),
      .PIL_W    (PIL_W),
      .TICK_BIT (TICK_BIT),
      .TIMER_BIT(TIMER_BIT),
      .THRESH   (THRESH)
   ) i_mask (
      .pend(pend),
      .pil (pil),
      .req (irq_req)
   );

   // Read path, zero-extended (R2)
   if (PAD_W > 0) begin : g_rd_pad
      assign rd_data = {{PAD_W{1'b0}}, pend};
   end else begin : g_rd_full
      assign rd_data = pend;
   end

   AST_SET_OR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_op == 2'd1) |=>
      ((pend & ($past(pend) | $past(wr_bits))) == ($past(pend) | $past(wr_bits)))); // R3

   AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_op == 2'd2 && !hw_timer_set) |=>
      ((pend & $past(wr_bits)) == '0 && (pend & ~$past(pend)) == '0)); // R4

   AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      hw_timer_set |=> pend[TIMER_BIT]); // R8

   AST_TIMER_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(pil) >= THRESH) |-> (!irq_req[TICK_BIT] && !irq_req[TIMER_BIT])); // R5

   AST_REQ_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ((irq_req & ~rd_data[NUM_BITS-1:0]) == '0)); // R6

   AST_TOP_LEVEL_CUT: assert property (@(posedge clk) disable iff (!rst_n)
      (pil == '1) |-> (irq_req[(1 << PIL_W) - 1:1] == '0)); // R6

endmodule

// File: tb/test_sip_softint_reg.sv
module test_sip_softint_reg;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_op = 2'd3;
   logic [63:0] wr_data = '0;
   logic [3:0]  pil = 4'd0;
   logic        hw_timer_set = 1'b0;
   logic [63:0] rd_data;
   logic [16:0] irq_req;

   int    n_chk = 0;
   int    n_bad = 0;
   string tag = "R1";
   logic [16:0] m = '0;
   bit    done = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   sip_softint_reg i_sip_softint_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op),
      .wr_data(wr_data), .pil(pil), .hw_timer_set(hw_timer_set),
      .rd_data(rd_data), .irq_req(irq_req)
   );

   function automatic logic [16:0] exp_req(logic [16:0] p, logic [3:0] l);
      logic [16:0] r;
      r = '0;
      for (int i = 0; i < 17; i++) begin
         if (i == 0 || i == 16) r[i] = p[i] && (int'(l) < 14);
         else                   r[i] = p[i] && (i > int'(l));
      end
      return r;
   endfunction

   // Reference model
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) m <= '0;
      else begin
         logic [16:0] v;
         v = m;
         if (wr_en) begin
            case (wr_op)
               2'd0: v = wr_data[16:0];
               2'd1: v = m | wr_data[16:0];
               2'd2: v = m & ~wr_data[16:0];
               default: v = m;
            endcase
         end
         if (hw_timer_set) v[16] = 1'b1;
         m <= v;
      end
   end

   // Compare every cycle, after inputs have settled
   always begin
      @(negedge clk);
      #2;
      if (!done) begin
         n_chk++;
         if (rd_data !== {47'b0, m}) begin
            n_bad++;
            $display("FAIL %s rd_data actual %h expected %h", tag, rd_data, {47'b0, m});
         end
         n_chk++;
         if (irq_req !== exp_req(m, pil)) begin
            n_bad++;
            $display("FAIL %s irq_req actual %h expected %h pil %0d", tag, irq_req, exp_req(m, pil), pil);
         end
      end
   end

   task automatic wr(input logic [1:0] op, input logic [63:0] d, input logic hw);
      @(negedge clk);
      wr_en = 1'b1; wr_op = op; wr_data = d; hw_timer_set = hw;
      @(negedge clk);
      wr_en = 1'b0; wr_op = 2'd3; wr_data = '0; hw_timer_set = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      #3000000;
      n_bad++; n_chk++;
      $display("FAIL watchdog expired actual hung expected done");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      tag = "R1"; idle(3);
      @(negedge clk); rst_n = 1'b1; idle(2);
      tag = "R2"; wr(2'd0, 64'hDEAD_BEEF_0001_5A5A, 1'b0); idle(1);
      wr(2'd0, 64'hFFFF_FFFF_FFFE_0000, 1'b0); idle(1);
      wr(2'd0, 64'h0, 1'b0);
      tag = "R3"; wr(2'd1, 64'h00F0, 1'b0); wr(2'd1, 64'hFFFF_0000_0000_0003, 1'b0); idle(1);
      tag = "R4"; wr(2'd2, 64'h0030, 1'b0); wr(2'd2, 64'h0001, 1'b0); idle(1);
      tag = "R6"; wr(2'd0, 64'h1_FFFF, 1'b0);
      for (int l = 0; l < 16; l++) begin
         @(negedge clk);
         pil = 4'(l);
         tag = (l >= 13) ? "R5" : "R7";
      end
      tag = "R6"; wr(2'd0, 64'h1_8001, 1'b0);
      for (int l = 15; l >= 0; l--) begin @(negedge clk); pil = 4'(l); end
      tag = "R8"; wr(2'd2, 64'h1_FFFF, 1'b1); idle(1);
      wr(2'd0, 64'h0, 1'b1); idle(1);
      wr(2'd1, 64'h0, 1'b1);
      tag = "R9"; wr(2'd3, 64'h1_FFFF, 1'b0); idle(1);
      @(negedge clk); wr_en = 1'b0; wr_op = 2'd0; wr_data = 64'h0;
      @(negedge clk); wr_op = 2'd2; wr_data = 64'h1_FFFF;
      @(negedge clk); wr_op = 2'd3; wr_data = '0;
      tag = "R6";
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         wr_en = 1'($urandom);
         wr_op = 2'($urandom);
         wr_data = {$urandom, $urandom};
         hw_timer_set = (($urandom % 8) == 0);
         pil = 4'($urandom);
      end
      @(negedge clk);
      wr_en = 1'b0; wr_op = 2'd3; hw_timer_set = 1'b0;
      tag = "R1"; rst_n = 1'b0; idle(2);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule